// File: doc/BRIEF.md
# Host Controller for a No-Bus-Latency Flow-Through SRAM

This block sits between an on-chip requester and a synchronous flow-through SRAM that needs no bus turnaround cycles. The requester hands over one request at a time on a valid/ready channel. Each request carries a word address, a burst length of one to four beats, per-beat byte enables and per-beat write data. The controller turns each request into a memory command: select, write-enable polarity and a freshly loaded address. Further beats of the request are issued with the advance strobe, and no new address is driven for them.

The memory takes write data one cycle after the command that names it, and returns read data in the cycle after a read command. The controller carries that one-cycle skew in a small data-phase register. Because of this, reads and writes can follow each other on consecutive cycles with no idle cycle between them. Each read beat is returned to the requester with a valid strobe and the beat's word address. The beat address follows the burst order chosen by a strap input. When the requester holds off a response, the controller raises the memory's clock-enable-inactive signal, and both the memory and the controller freeze for that cycle.

Top module: `nbl_host_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the memory is deselected. In that state the advance strobe is low, the write strobe is high, all byte selects are high (inactive), the data bus is not driven, the output-enable is low, clock enable is active, `rsp_valid` is low and `req_ready` is high.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) appears in the next cycle as a load command. In a load command all three selects are active, advance is low, `mem_addr` equals `req_addr`, and `mem_wr_n` is 0 for a write (`req_write`=1) and 1 for a read.
- R3: `req_len` holds the beat count minus one. A request of N beats is followed by N-1 cycles with advance high. `req_ready` stays low in those cycles except in the one that carries the last beat, so the next request loads in the cycle right after the last beat.
- R4: Each write beat drives `mem_dq_out` with its data, `mem_dq_oe` high and `mem_out_en_n` high in the cycle after its command cycle. `mem_bytesel_n` in that cycle is the inverse of the beat's enables. Outside such cycles the bus is released, `mem_out_en_n` is low and all byte selects are high.
- R5: Read beats come back in request order on `rsp_valid`/`rsp_data`. Each carries the memory word stored at its beat address.
- R6: `rsp_addr` tags each returned beat. Address bits above bit 1 equal the request's. Bits [1:0] are (base+k) mod 4 for beat k when `cfg_interleave`=0, and base XOR k when `cfg_interleave`=1. The same order is presented to the memory on `mem_burst_ilv`.
- R7: Single-beat reads and writes can be accepted on consecutive cycles in any mix, one per cycle, when responses are not held off.
- R8: While `rsp_valid` is high and `rsp_ready` low, `mem_clken_n` is high and `req_ready` is low. In the following cycle every memory-side output and the response outputs are unchanged.
- R9: With no request pending, the controller issues a deselect with advance low. The first access after a deselect is a load with advance low.
- R10: Beat k's byte enables are `req_be[k*4 +: 4]`; bit b covers data bits [8b+7:8b]. Bytes with enable 0 keep their old memory contents. Beat k's data is `req_wdata[k*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_interleave | input | 1 | Burst order strap: 0 linear, 1 interleaved; change only while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Start word address |
| req_len | input | 2 | Beats minus one |
| req_be | input | 4*NB | Byte enables, NB per beat |
| req_wdata | input | 4*DW | Write data, DW per beat |
| rsp_valid | output | 1 | Read beat present |
| rsp_ready | input | 1 | Requester takes the read beat |
| rsp_data | output | DW | Read beat data |
| rsp_addr | output | AW | Word address of the read beat |
| mem_clken_n | output | 1 | Memory clock enable, active low |
| mem_en_a_n | output | 1 | Select, active low |
| mem_en_b | output | 1 | Select, active high |
| mem_en_c_n | output | 1 | Select, active low |
| mem_advance | output | 1 | 1 continue burst, 0 load address |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_bytesel_n | output | NB | Byte selects, active low |
| mem_dq_out | output | DW | Write data to bus |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DW | Data from bus |
| mem_out_en_n | output | 1 | Memory output enable, active low |
| mem_burst_ilv | output | 1 | Burst order to memory |

## Verification
Several properties are checked on every cycle. A stall freezes all memory-side and response outputs, and no request is accepted during it. An accepted request becomes a load command with its own address and write polarity. A write command is followed by a driven data phase, and a bus turn-on always follows a write command. Any select after a deselect loads with advance low. Returned data values, request ordering and the burst-order beat tags can only be shown by the bench's scenarios. In those scenarios a behavioural memory and a scoreboard run the controller against mixed bursts, wrap-around starts, partial byte writes, back-to-back read/write alternation and random back-pressure.

// File: rtl/nbl_host_pkg.sv
package nbl_host_pkg;
  // The memory bursts within an aligned group of four words
  localparam int GROUP = 4;
  localparam int GW    = $clog2(GROUP);

  // low address bits of beat k of a burst starting at base
  function automatic logic [GW-1:0] beat_lsb(input logic [GW-1:0] base,
                                             input logic [GW-1:0] k,
                                             input logic          ilv);
    logic [GW-1:0] r;
    if (ilv) r = base ^ k;
    else     r = base + k;
    return r;
  endfunction
endpackage

// File: rtl/nbl_cmd_stage.sv
module nbl_cmd_stage
  import nbl_host_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv_en,
  input  logic                  cfg_ilv,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [GW-1:0]         req_len,
  input  logic [GROUP*NB-1:0]   req_be,
  input  logic [GROUP*DW-1:0]   req_wdata,
  output logic                  sel,
  output logic                  advance,
  output logic                  wr_n,
  output logic [AW-1:0]         addr,
  output logic                  accept,
  output logic                  cont,
  output logic                  beat_wr,
  output logic [AW-1:0]         beat_addr,
  output logic [DW-1:0]         beat_data,
  output logic [NB-1:0]         beat_be
);
  logic          act_q;
  logic [GW-1:0] left_q, idx_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] wbuf [GROUP];
  logic [NB-1:0] bbuf [GROUP];
  logic          last_beat;

  assign last_beat = !act_q || (left_q == '0);
  assign req_ready = adv_en && last_beat;
  assign accept    = req_valid && req_ready;
  assign cont      = adv_en && act_q && (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      beat_wr <= 1'b0;
      left_q  <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      advance <= 1'b0;
      wr_n    <= 1'b1;
      addr    <= '0;
    end else if (cont) begin
      advance <= 1'b1;
      left_q  <= left_q - 1'b1;
      idx_q   <= idx_q + 1'b1;
    end else if (accept) begin
      act_q   <= 1'b1;
      beat_wr <= req_write;
      left_q  <= req_len;
      idx_q   <= '0;
      base_q  <= req_addr;
      advance <= 1'b0;
      wr_n    <= !req_write;
      addr    <= req_addr;
    end else if (adv_en) begin
      act_q   <= 1'b0;
      advance <= 1'b0;
      wr_n    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int k = 0; k < GROUP; k++) begin
        wbuf[k] <= req_wdata[k*DW +: DW];
        bbuf[k] <= req_be[k*NB +: NB];
      end
    end
  end

  assign sel       = act_q;
  assign beat_addr = {base_q[AW-1:GW], beat_lsb(base_q[GW-1:0], idx_q, cfg_ilv)};
  assign beat_data = wbuf[idx_q];
  assign beat_be   = bbuf[idx_q];
endmodule

// File: rtl/nbl_data_stage.sv
module nbl_data_stage #(
  parameter int AW = 17,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          beat_act,
  input  logic          beat_wr,
  input  logic [AW-1:0] beat_addr,
  input  logic [DW-1:0] beat_data,
  input  logic [NB-1:0] beat_be,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          out_en_n,
  output logic [NB-1:0] bytesel_n,
  output logic          dph_rd,
  output logic [AW-1:0] dph_addr
);
  logic wphase;
  assign wphase = beat_act && beat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      out_en_n  <= 1'b0;
      bytesel_n <= '1;
      dph_rd    <= 1'b0;
      dph_addr  <= '0;
    end else if (adv_en) begin
      dq_oe     <= wphase;
      out_en_n  <= wphase;
      bytesel_n <= wphase ? ~beat_be : '1;
      dq_out    <= wphase ? beat_data : '0;
      dph_rd    <= beat_act && !beat_wr;
      dph_addr  <= beat_addr;
    end
  end
endmodule

// File: rtl/nbl_rsp_stage.sv
module nbl_rsp_stage #(
  parameter int AW = 17,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_ready,
  input  logic          dph_rd,
  input  logic [AW-1:0] dph_addr,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] rsp_addr,
  output logic          stall
);
  assign stall = rsp_valid && !rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_addr  <= '0;
    end else if (!stall) begin
      rsp_valid <= dph_rd;
      if (dph_rd) begin
        rsp_data <= dq_in;
        rsp_addr <= dph_addr;
      end
    end
  end
endmodule

// File: rtl/nbl_host_ctrl.sv
module nbl_host_ctrl
  import nbl_host_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_interleave,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [GW-1:0]       req_len,
  input  logic [GROUP*NB-1:0] req_be,
  input  logic [GROUP*DW-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_data,
  output logic [AW-1:0]       rsp_addr,
  output logic                mem_clken_n,
  output logic                mem_en_a_n,
  output logic                mem_en_b,
  output logic                mem_en_c_n,
  output logic                mem_advance,
  output logic                mem_wr_n,
  output logic [AW-1:0]       mem_addr,
  output logic [NB-1:0]       mem_bytesel_n,
  output logic [DW-1:0]       mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DW-1:0]       mem_dq_in,
  output logic                mem_out_en_n,
  output logic                mem_burst_ilv
);
  // internal events, named for the checker
  logic          stall_w, adv_en_w, accept_w, cont_w, sel_w;
  logic          beat_wr_w, dph_rd_w;
  logic [AW-1:0] beat_addr_w, dph_addr_w;
  logic [DW-1:0] beat_data_w;
  logic [NB-1:0] beat_be_w;

  assign adv_en_w = !stall_w;

  nbl_cmd_stage #(.AW(AW), .DW(DW), .NB(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en_w), .cfg_ilv(cfg_interleave),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
    .sel(sel_w), .advance(mem_advance), .wr_n(mem_wr_n), .addr(mem_addr),
    .accept(accept_w), .cont(cont_w), .beat_wr(beat_wr_w), .beat_addr(beat_addr_w),
    .beat_data(beat_data_w), .beat_be(beat_be_w)
  );

  nbl_data_stage #(.AW(AW), .DW(DW), .NB(NB)) u_data (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en_w), .beat_act(sel_w),
    .beat_wr(beat_wr_w), .beat_addr(beat_addr_w), .beat_data(beat_data_w),
    .beat_be(beat_be_w), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe),
    .out_en_n(mem_out_en_n), .bytesel_n(mem_bytesel_n),
    .dph_rd(dph_rd_w), .dph_addr(dph_addr_w)
  );

  nbl_rsp_stage #(.AW(AW), .DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rsp_ready(rsp_ready), .dph_rd(dph_rd_w),
    .dph_addr(dph_addr_w), .dq_in(mem_dq_in), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_addr(rsp_addr), .stall(stall_w)
  );

  assign mem_clken_n   = stall_w;
  assign mem_en_a_n    = !sel_w;
  assign mem_en_b      = sel_w;
  assign mem_en_c_n    = !sel_w;
  assign mem_burst_ilv = cfg_interleave;
endmodule

// File: rtl/nbl_host_chk.sv
module nbl_host_chk #(
  parameter int AW = 17,
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] rsp_addr,
  input logic          mem_clken_n,
  input logic          mem_en_b,
  input logic          mem_advance,
  input logic          mem_wr_n,
  input logic [AW-1:0] mem_addr,
  input logic [NB-1:0] mem_bytesel_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          stall
);
  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(mem_addr) && $stable(mem_advance) && $stable(mem_wr_n) &&
              $stable(mem_en_b) && $stable(mem_dq_out) && $stable(mem_dq_oe) &&
              $stable(mem_bytesel_n) && $stable(rsp_valid) && $stable(rsp_data) &&
              $stable(rsp_addr));

  assert_stall_blocks_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> mem_clken_n && !req_ready);

  assert_load_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_en_b && !mem_advance &&
                               mem_addr == $past(req_addr) && mem_wr_n == !$past(req_write));

  assert_write_data_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_clken_n && mem_en_b && !mem_wr_n |=> mem_dq_oe);

  assert_bus_on_only_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_en_b && !mem_wr_n && !mem_clken_n));

  assert_bytesel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_dq_oe |-> &mem_bytesel_n);

  assert_load_after_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_b) |-> !mem_advance);

  assert_rsp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid);
endmodule

bind nbl_host_ctrl nbl_host_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_addr(rsp_addr),
  .mem_clken_n(mem_clken_n), .mem_en_b(mem_en_b), .mem_advance(mem_advance),
  .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_bytesel_n(mem_bytesel_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .stall(stall_w)
);

// File: tb/tb_nbl_host_ctrl.sv
`timescale 1ns/1ps
module tb_nbl_host_ctrl;
  localparam int AW = 17;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int NV = 16;
  // {write, addr[5:0], len, be, pad}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 6'd8,  2'd3, 4'hF, 3'd0}, {1'b0, 6'd8,  2'd3, 4'hF, 3'd0},
    {1'b0, 6'd9,  2'd3, 4'hF, 3'd0}, {1'b1, 6'd13, 2'd1, 4'hF, 3'd0},
    {1'b0, 6'd15, 2'd0, 4'hF, 3'd0}, {1'b1, 6'd15, 2'd0, 4'h3, 3'd0},
    {1'b0, 6'd15, 2'd0, 4'hF, 3'd0}, {1'b0, 6'd12, 2'd2, 4'hF, 3'd0},
    {1'b1, 6'd20, 2'd0, 4'hF, 3'd0}, {1'b0, 6'd20, 2'd0, 4'hF, 3'd0},
    {1'b1, 6'd21, 2'd0, 4'hF, 3'd0}, {1'b0, 6'd21, 2'd0, 4'hF, 3'd0},
    {1'b1, 6'd22, 2'd3, 4'hA, 3'd0}, {1'b0, 6'd23, 2'd3, 4'hF, 3'd0},
    {1'b1, 6'd3,  2'd0, 4'h0, 3'd0}, {1'b0, 6'd3,  2'd0, 4'hF, 3'd0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_interleave = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_len = '0;
  logic [4*NB-1:0] req_be = '0;
  logic [4*DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] rsp_addr;
  logic mem_clken_n, mem_en_a_n, mem_en_b, mem_en_c_n, mem_advance, mem_wr_n;
  logic [AW-1:0] mem_addr;
  logic [NB-1:0] mem_bytesel_n;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic mem_dq_oe, mem_out_en_n, mem_burst_ilv;

  nbl_host_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_interleave(cfg_interleave),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_addr(rsp_addr),
    .mem_clken_n(mem_clken_n), .mem_en_a_n(mem_en_a_n), .mem_en_b(mem_en_b),
    .mem_en_c_n(mem_en_c_n), .mem_advance(mem_advance), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_bytesel_n(mem_bytesel_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_out_en_n(mem_out_en_n),
    .mem_burst_ilv(mem_burst_ilv)
  );

  // ---------------- behavioural memory ----------------
  logic [DW-1:0] marr [64];
  logic m_act, m_wr, p_wr, p_rd;
  logic [5:0] m_base, p_a;
  logic [1:0] m_idx;
  int bus_err = 0;

  always @(posedge clk) begin : model
    logic [1:0] nx;
    if (!rst_n) begin
      m_act <= 0; m_wr <= 0; p_wr <= 0; p_rd <= 0; m_base <= 0; p_a <= 0; m_idx <= 0;
    end else if (!mem_clken_n) begin
      if (p_wr) begin
        if (!mem_dq_oe) bus_err <= bus_err + 1;
        for (int b = 0; b < NB; b++)
          if (!mem_bytesel_n[b]) marr[p_a][b*8 +: 8] <= mem_dq_out[b*8 +: 8];
      end else if (mem_dq_oe) bus_err <= bus_err + 1;
      if (mem_advance) begin
        nx = m_idx + 2'd1;
        if (m_act) begin
          m_idx <= nx;
          p_a   <= mem_burst_ilv ? {m_base[5:2], m_base[1:0] ^ nx} : {m_base[5:2], m_base[1:0] + nx};
          p_wr  <= m_wr;
          p_rd  <= !m_wr;
        end else begin
          p_wr <= 0; p_rd <= 0;
        end
      end else if (!mem_en_a_n && mem_en_b && !mem_en_c_n) begin
        m_act <= 1; m_wr <= !mem_wr_n; m_base <= mem_addr[5:0]; m_idx <= 0;
        p_a <= mem_addr[5:0]; p_wr <= !mem_wr_n; p_rd <= mem_wr_n;
      end else begin
        m_act <= 0; p_wr <= 0; p_rd <= 0;
      end
    end
  end
  assign mem_dq_in = p_rd ? marr[p_a] : '0;

  // ---------------- scoreboard ----------------
  logic [DW-1:0] shadow [64];
  logic [37:0] expq [$];
  int n_chk = 0, n_bad = 0, cyc = 0, wserial = 0, last_acc = 0, bp = 0;
  logic [DW-1:0] last_rsp = '0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] tb_beat(input logic [5:0] b, input int k, input logic ilv);
    int lo;
    if (ilv) lo = int'(b[1:0]) ^ k;
    else     lo = (int'(b[1:0]) + k) % 4;
    return {b[5:2], 2'(lo)};
  endfunction

  function automatic logic [DW-1:0] wgen(input int n, input int k);
    return 32'h5A3C_0000 ^ (n * 32'h0001_0203) ^ (k << 28);
  endfunction

  function automatic logic [3:0] rotl(input logic [3:0] v, input int k);
    logic [7:0] d;
    d = {v, v} << (k % 4);
    return d[7:4];
  endfunction

  function automatic logic pick();
    if (bp == 0) return 1'b1;
    if (bp == 2) return 1'b0;
    return ($urandom % 3) != 0;
  endfunction

  task automatic take_rsp();
    logic [37:0] e;
    if (rsp_valid && rsp_ready) begin
      if (expq.size() == 0) check("R5 unexpected response", 1, 0);
      else begin
        e = expq.pop_front();
        check("R5 read data", rsp_data, e[31:0]);
        check("R6 beat address", rsp_addr, {11'b0, e[37:32]});
        last_rsp = rsp_data;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rsp_ready = pick(); #1; take_rsp(); @(negedge clk);
    end
  endtask

  task automatic drain();
    int g = 0;
    while ((expq.size() != 0 || rsp_valid) && g < 200) begin idle(1); g++; end
    idle(2);
    check("R5 all reads returned", expq.size(), 0);
  endtask

  task automatic issue(input bit wr, input logic [5:0] a, input logic [1:0] len, input logic [3:0] be);
    logic [4*DW-1:0] wd;
    logic [4*NB-1:0] bes;
    logic [5:0] ba;
    bit acc = 0;
    for (int k = 0; k < 4; k++) begin
      wd[k*DW +: DW]  = wgen(wserial, k);
      bes[k*NB +: NB] = rotl(be, k);
    end
    wserial++;
    req_write = wr; req_addr = {11'b0, a}; req_len = len; req_be = bes; req_wdata = wd;
    req_valid = 1'b1;
    while (!acc) begin
      rsp_ready = pick(); #1; take_rsp();
      if (req_ready) begin
        acc = 1; last_acc = cyc;
        for (int k = 0; k <= int'(len); k++) begin
          ba = tb_beat(a, k, cfg_interleave);
          if (wr) begin
            for (int b = 0; b < NB; b++)
              if (bes[k*NB + b]) shadow[ba][b*8 +: 8] = wd[k*DW + b*8 +: 8];
          end else expq.push_back({ba, shadow[ba]});
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    int acc_c [6];
    int c0;
    logic [DW-1:0] va, vb, d0;
    logic [AW-1:0] a0;
    for (int i = 0; i < 64; i++) begin
      marr[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
      shadow[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
    end
    repeat (3) @(negedge clk);
    #1;
    check("R1 select in reset", {mem_en_a_n, mem_en_b, mem_en_c_n}, 3'b101);
    check("R1 advance/write in reset", {mem_advance, mem_wr_n}, 2'b01);
    check("R1 byte selects in reset", mem_bytesel_n, 4'hF);
    check("R1 bus and outen in reset", {mem_dq_oe, mem_out_en_n, mem_clken_n}, 3'b000);
    check("R1 handshake in reset", {rsp_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after reset", {mem_en_b, mem_advance, mem_dq_oe, rsp_valid, req_ready}, 5'b00001);
    @(negedge clk);

    // table walk: linear/no back-pressure, then interleaved/random back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      cfg_interleave = pass[0]; bp = pass;
      idle(2);
      for (int i = 0; i < NV; i++)
        issue(VEC[i][15], VEC[i][14:9], VEC[i][8:7], VEC[i][6:3]);
      drain();
    end
    check("R6 order pin follows strap", mem_burst_ilv, 1'b1);

    // random traffic
    bp = 1;
    for (int i = 0; i < 300; i++) begin
      if (i == 150) begin drain(); cfg_interleave = 1'b0; end
      issue(1'($urandom), 6'($urandom), 2'($urandom), 4'($urandom));
    end
    drain();
    bp = 0; cfg_interleave = 1'b0;

    // R7: alternating singles, one accepted per cycle
    for (int i = 0; i < 6; i++) begin
      issue(i[0] == 1'b0, 6'd48 + 6'(i / 2), 2'd0, 4'hF);
      acc_c[i] = last_acc;
    end
    for (int i = 1; i < 6; i++) check("R7 back-to-back accept gap", acc_c[i] - acc_c[i-1], 1);
    drain();

    // R3: burst then next request, gap equals burst length
    issue(1'b1, 6'd32, 2'd3, 4'hF); c0 = last_acc;
    issue(1'b0, 6'd32, 2'd3, 4'hF);
    check("R3 next request after 4-beat burst", last_acc - c0, 4);
    drain();

    // R2/R3: observe a burst command sequence
    issue(1'b1, 6'd34, 2'd3, 4'hF);
    #1;
    check("R2 load command", {mem_en_b, mem_advance, mem_wr_n}, 3'b100);
    check("R2 load address", mem_addr, 17'd34);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); #1;
      check("R3 advance on continuation", mem_advance, 1'b1);
      check("R3 ready only on last beat", req_ready, 1'(k == 3));
    end
    @(negedge clk); #1;
    @(negedge clk); #1;
    check("R9 deselect with advance low", {mem_en_b, mem_advance}, 2'b00);
    @(negedge clk);

    // R4: write data phase and release
    issue(1'b1, 6'd44, 2'd0, 4'b0110); va = wgen(wserial - 1, 0);
    #1;
    check("R2 write strobe on write", mem_wr_n, 1'b0);
    @(negedge clk); #1;
    check("R4 bus driven in data cycle", {mem_dq_oe, mem_out_en_n}, 2'b11);
    check("R4 byte selects in data cycle", mem_bytesel_n, 4'b1001);
    check("R4 write data on bus", mem_dq_out, va);
    @(negedge clk); #1;
    check("R4 bus released after data", {mem_dq_oe, mem_out_en_n}, 2'b00);
    check("R4 byte selects idle", mem_bytesel_n, 4'hF);
    @(negedge clk);

    // R10: partial byte write keeps unselected bytes
    issue(1'b1, 6'd40, 2'd0, 4'hF); va = wgen(wserial - 1, 0);
    issue(1'b1, 6'd40, 2'd0, 4'b0101); vb = wgen(wserial - 1, 0);
    issue(1'b0, 6'd40, 2'd0, 4'hF);
    drain();
    check("R10 merged bytes", last_rsp, {va[31:24], vb[23:16], va[15:8], vb[7:0]});

    // R8: stall holds everything
    bp = 2;
    issue(1'b0, 6'd8, 2'd0, 4'hF);
    issue(1'b0, 6'd9, 2'd1, 4'hF);
    for (int g = 0; g < 10 && !rsp_valid; g++) begin rsp_ready = 1'b0; #1; if (!rsp_valid) @(negedge clk); end
    #1;
    d0 = rsp_data; a0 = mem_addr;
    for (int k = 0; k < 4; k++) begin
      check("R8 clock enable inactive in stall", {rsp_valid, mem_clken_n, req_ready}, 3'b110);
      check("R8 response held", rsp_data, d0);
      check("R8 memory address held", mem_addr, a0);
      @(negedge clk); rsp_ready = 1'b0; #1;
    end
    @(negedge clk);
    bp = 0;
    drain();

    check("R4 no bus fault seen by memory", bus_err, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule